// File: doc/BRIEF.md
# Delay-Time Glide Tracker

This block holds the delay offset that a delay-line buffer actually uses, and moves it toward a requested delay one bounded step per audio frame. The requested value may change at any moment. The offset never jumps to it; it glides toward it instead. A jump would produce an audible click. The glide causes a brief pitch bend while the delay is moving.

On each frame strobe the tracker compares the target with the current offset as unsigned numbers. A larger target makes the offset grow by four address units. A smaller target makes it shrink by two. An equal target leaves it where it is. The arithmetic is modulo 2^18. Targets are normally multiples of four. With those targets, the uneven step sizes still bring the offset to the target exactly, and it then stays there. Address generation and smoothing of the control input are done elsewhere.

Top module: `delay_glide_tracker`

## Requirements
- R1: The offset changes only on a clock edge where `frame_i` is high, and the new value appears on `delay_o` after that edge. Without a strobe, `delay_o` keeps its value whatever `target_i` does.
- R2: The target and the offset are compared as unsigned 18-bit numbers. A target with bit 17 set counts as larger than any offset below it.
- R3: On a strobe where `target_i` equals `delay_o`, the offset stays unchanged.
- R4: On a strobe where `target_i` is greater than `delay_o`, the offset increases by 4.
- R5: On a strobe where `target_i` is less than `delay_o`, the offset decreases by 2.
- R6: Each step is truncated to 18 bits, so an increase from 0x3FFFC gives 0x00000.
- R7: While `rst_n` is low and after it is released, `delay_o` holds 0x00100 until the first strobe.
- R8: For a target that is a multiple of 4, repeated strobes bring the offset to the target exactly, and further strobes hold it there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | One-cycle frame strobe that allows one step |
| target_i | input | 18 | Requested delay, in address units |
| delay_o | output | 18 | Current delay offset, registered |

## Verification
The bound checker checks the single-step rules on every cycle. With no strobe the output holds. An equal target holds. A larger target adds exactly four, wrapping at 18 bits. A smaller target subtracts exactly two. The reset value, the convergence to a target followed by a stable hold, and the wrap after tens of thousands of upward steps are behaviours that only span many frames. These are shown by the bench scenarios: a directed approach from above and below, a long run up to the top of the range, and random strobes and targets compared against a bench model.

// File: rtl/glide_pkg.sv
package glide_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } glide_dir_e;
endpackage

// File: rtl/glide_cmp.sv
module glide_cmp
    import glide_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic [DW-1:0] target_i,
    input  logic [DW-1:0] current_i,
    output glide_dir_e    dir_o
);
    always_comb begin
        if (target_i > current_i) begin
            dir_o = DIR_UP;
        end else if (target_i < current_i) begin
            dir_o = DIR_DOWN;
        end else begin
            dir_o = DIR_HOLD;
        end
    end
endmodule

// File: rtl/glide_step.sv
module glide_step
    import glide_pkg::*;
#(
    parameter int DW      = 18,
    parameter int UP_STEP = 4,
    parameter int DN_STEP = 2
) (
    input  glide_dir_e    dir_i,
    input  logic [DW-1:0] current_i,
    output logic [DW-1:0] next_o
);
    localparam logic [DW-1:0] UP_V = DW'(UP_STEP);
    localparam logic [DW-1:0] DN_V = DW'(DN_STEP);

    always_comb begin
        unique case (dir_i)
            DIR_UP:   next_o = current_i + UP_V;
            DIR_DOWN: next_o = current_i - DN_V;
            default:  next_o = current_i;
        endcase
    end
endmodule

// File: rtl/delay_glide_tracker.sv
module delay_glide_tracker
    import glide_pkg::*;
#(
    parameter int          DW        = 18,
    parameter int          UP_STEP   = 4,
    parameter int          DN_STEP   = 2,
    parameter logic [17:0] INIT_DLY  = 18'h00100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic [DW-1:0] target_i,
    output logic [DW-1:0] delay_o
);
    localparam logic [DW-1:0] INIT_V = DW'(INIT_DLY);

    typedef struct packed {
        logic [DW-1:0] delay;
    } glide_state_t;

    glide_state_t  st_d, st_q;
    glide_dir_e    dir;
    logic [DW-1:0] stepped;

    glide_cmp #(.DW(DW)) u_cmp (
        .target_i  (target_i),
        .current_i (st_q.delay),
        .dir_o     (dir)
    );

    glide_step #(.DW(DW), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) u_step (
        .dir_i     (dir),
        .current_i (st_q.delay),
        .next_o    (stepped)
    );

    always_comb begin
        st_d = st_q;
        if (frame_i) begin
            st_d.delay = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.delay <= INIT_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign delay_o = st_q.delay;
endmodule

// File: rtl/delay_glide_tracker_chk.sv
module delay_glide_tracker_chk #(
    parameter int DW      = 18,
    parameter int UP_STEP = 4,
    parameter int DN_STEP = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_i,
    input logic [DW-1:0] target_i,
    input logic [DW-1:0] delay_o
);
    localparam logic [DW-1:0] UP_V = DW'(UP_STEP);
    localparam logic [DW-1:0] DN_V = DW'(DN_STEP);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(delay_o)); // R1

    AST_EQUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && target_i == delay_o) |=> $stable(delay_o)); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && target_i > delay_o) |=> delay_o == $past(delay_o) + UP_V); // R4

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && target_i < delay_o) |=> delay_o == $past(delay_o) - DN_V); // R5

    AST_TOP_BIT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && target_i[DW-1] && !delay_o[DW-1]) |=> delay_o != $past(delay_o) - DN_V); // R2
endmodule

bind delay_glide_tracker delay_glide_tracker_chk #(
    .DW(DW), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .target_i(target_i), .delay_o(delay_o)
);

// File: tb/delay_glide_tracker_tb.sv
module delay_glide_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_i;
    logic [17:0] target_i;
    logic [17:0] delay_o;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic [17:0] exp_q;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    delay_glide_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
        .target_i(target_i), .delay_o(delay_o)
    );

    function automatic logic [17:0] ref_next(logic [17:0] cur, logic [17:0] tgt);
        if (tgt > cur) return cur + 18'd4;
        if (tgt < cur) return cur - 18'd2;
        return cur;
    endfunction

    task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: delay_o=%05h expected %05h", req, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, sample at next falling edge
    task automatic step(logic fr, logic [17:0] tgt);
        frame_i  = fr;
        target_i = tgt;
        @(negedge clk);
        if (fr) exp_q = ref_next(exp_q, tgt);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame_i = 1'b1; target_i = 18'h3FFFF;
        repeat (3) @(negedge clk);
        chk("R7", delay_o, 18'h00100);
        rst_n = 1'b1; frame_i = 1'b0;
        exp_q = 18'h00100;
        @(negedge clk);
        chk("R7", delay_o, 18'h00100);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; frame_i = 1'b0; target_i = '0;
        @(negedge clk);
        do_reset();

        // R1: target far away, no strobe
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 18'h20000);
            chk("R1", delay_o, 18'h00100);
        end
        // R2: bit 17 set counts as larger
        step(1'b1, 18'h20000);
        chk("R2", delay_o, 18'h00104);
        // R4: larger target
        step(1'b1, 18'h00200);
        chk("R4", delay_o, 18'h00108);
        // R5: smaller target
        step(1'b1, 18'h00040);
        chk("R5", delay_o, 18'h00106);
        // R3: equal target holds
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 18'h00106);
            chk("R3", delay_o, 18'h00106);
        end
        // R8: approach from above, then from below with an offset of 2
        for (int i = 0; i < 200; i++) step(1'b1, 18'h000C0);
        chk("R8", delay_o, 18'h000C0);
        step(1'b1, 18'h000BC);
        chk("R5", delay_o, 18'h000BE);
        for (int i = 0; i < 200; i++) step(1'b1, 18'h00120);
        chk("R8", delay_o, 18'h00120);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 18'h00120);
            chk("R8", delay_o, 18'h00120);
        end

        // random strobes and nearby targets, each cycle checked against the model
        for (int i = 0; i < 4000; i++) begin
            logic [17:0] t;
            t = 18'h00100 + 18'(($urandom % 64) * 4);
            step(logic'($urandom % 2), t);
            chk("R1", delay_o, exp_q);
        end

        // R6: climb to the top of the range and wrap
        do_reset();
        for (int i = 0; i < 65471; i++) step(1'b1, 18'h3FFFF);
        chk("R4", delay_o, 18'h3FFFC);
        step(1'b1, 18'h3FFFF);
        chk("R6", delay_o, 18'h00000);
        step(1'b1, 18'h3FFFF);
        chk("R6", delay_o, 18'h00004);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule